// File: doc/BRIEF.md
# Hand-Programmable Address Register and Byte Store

This block pairs a 4-bit address register with a sixteen-entry byte store. Both share a single data bus, so there is no separate address bus at the block's edge. The CPU first loads an address from the low bits of the bus. It can then write the bus byte into the store or read the stored byte back onto the bus. The only dedicated address path runs inside the block, from the register to the store.

Two manual modes let a program be keyed in while the CPU is halted. In test mode, a 4-bit switch value chooses the location instead of the register. This holds for both reads and writes. In programming mode, the CPU's store-write control is shut out. Each press of a write button then stores an 8-bit switch value at the chosen location. The button is taken as already clean. It is synchronised and edge-detected inside the block, so one press gives exactly one write.

Top module: `prog_mem_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, the address register holds 0, all sixteen locations hold 8'h00, `bus_out` is 8'h00 and `bus_out_en` is low.
- R2: On a rising clock edge with `addr_load` high, the address register takes `bus_in[3:0]`. Bits 7:4 of the bus are ignored. With `addr_load` low, the register keeps its value.
- R3: With `test_mode` high, `sw_addr` selects the location for reads and for both kinds of write, in place of the register. With `test_mode` low, the register selects it.
- R4: With `prog_mode` low and `mem_in` high, a rising clock edge stores `bus_in` at the selected location.
- R5: With `prog_mode` high, a low-to-high change of `wr_btn` stores `sw_data` at the selected location on the third rising clock edge after the change. This happens once per press, however long the button is held.
- R6: With `mem_out` high, `bus_out` shows the byte at the selected location in the same cycle and `bus_out_en` is high. With `mem_out` low, `bus_out` is 8'h00 and `bus_out_en` is low.
- R7: With `prog_mode` high, `mem_in` has no effect on the store.
- R8: With `prog_mode` low, pressing `wr_btn` has no effect on the store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_in | input | 8 | Byte read from the shared data bus |
| bus_out | output | 8 | Byte driven toward the shared bus, zero when idle |
| bus_out_en | output | 1 | High while the block drives the bus |
| addr_load | input | 1 | Load the address register from the bus |
| mem_in | input | 1 | Store the bus byte at the selected location |
| mem_out | input | 1 | Drive the selected byte onto the bus |
| test_mode | input | 1 | Use the switch address instead of the register |
| prog_mode | input | 1 | Manual programming: button writes, bus writes blocked |
| sw_addr | input | 4 | Switch address for test mode |
| sw_data | input | 8 | Switch data for programming mode |
| wr_btn | input | 1 | Manual write button, level, assumed bounce-free |

## Verification
The assertions assume that `wr_btn` is a slow level signal and that every control input changes only between clock edges. They also assume that the mode inputs stay steady while a button press is still in the synchroniser. The stimulus drives all inputs on the falling edge. It holds each button level for at least three cycles and changes `prog_mode` only after the button has been released and the synchroniser has settled. Writes and reads are swept over all sixteen locations in each mode, with data values the bench computes from the location number.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int unsigned PMU_ADDR_W = 4;
  localparam int unsigned PMU_DATA_W = 8;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_BUS  = 2'd1,
    SRC_SW   = 2'd2
  } wr_src_e;

  // Location used by the store: switches in test mode, register otherwise.
  function automatic logic [PMU_ADDR_W-1:0] pick_addr(
    input logic                  use_sw,
    input logic [PMU_ADDR_W-1:0] sw,
    input logic [PMU_ADDR_W-1:0] held
  );
    return use_sw ? sw : held;
  endfunction

  // Write source: manual mode owns the store, bus writes only outside it.
  function automatic wr_src_e pick_src(
    input logic manual,
    input logic press,
    input logic bus_wr
  );
    if (manual) return press ? SRC_SW : SRC_NONE;
    return bus_wr ? SRC_BUS : SRC_NONE;
  endfunction
endpackage

// File: rtl/pmu_addr_reg.sv
module pmu_addr_reg #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/pmu_press_detect.sv
module pmu_press_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn,
  output logic pulse
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[SYNC_STAGES-2:0], btn};
      last  <= chain[SYNC_STAGES-1];
    end
  end

  assign pulse = chain[SYNC_STAGES-1] & ~last;
endmodule

// File: rtl/pmu_store.sv
module pmu_store #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)                                   cells[g] <= '0;
      else if (we && addr == ADDR_W'(g))            cells[g] <= wdata;
    end
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/prog_mem_unit.sv
module prog_mem_unit #(
  parameter int unsigned ADDR_W = pmu_pkg::PMU_ADDR_W,
  parameter int unsigned DATA_W = pmu_pkg::PMU_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_out_en,
  input  logic              addr_load,
  input  logic              mem_in,
  input  logic              mem_out,
  input  logic              test_mode,
  input  logic              prog_mode,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [DATA_W-1:0] sw_data,
  input  logic              wr_btn
);
  import pmu_pkg::*;

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] eff_addr;
  logic              wr_pulse;
  wr_src_e           wr_src;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;

  pmu_addr_reg #(.ADDR_W(ADDR_W)) i_addr (
    .clk  (clk),
    .rst_n(rst_n),
    .load (addr_load),
    .d    (bus_in[ADDR_W-1:0]),
    .q    (addr_q)
  );

  pmu_press_detect #(.SYNC_STAGES(2)) i_press (
    .clk  (clk),
    .rst_n(rst_n),
    .btn  (wr_btn),
    .pulse(wr_pulse)
  );

  always_comb begin
    eff_addr = pick_addr(test_mode, sw_addr, addr_q);
    wr_src   = pick_src(prog_mode, wr_pulse, mem_in);
    wr_en    = (wr_src != SRC_NONE);
    wr_data  = (wr_src == SRC_SW) ? sw_data : bus_in;
  end

  pmu_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_en),
    .addr (eff_addr),
    .wdata(wr_data),
    .rdata(rd_data)
  );

  assign bus_out_en = mem_out;
  assign bus_out    = mem_out ? rd_data : '0;
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_load,
  input logic [DATA_W-1:0] bus_in,
  input logic [ADDR_W-1:0] addr_q,
  input logic [ADDR_W-1:0] eff_addr,
  input logic              test_mode,
  input logic [ADDR_W-1:0] sw_addr,
  input logic              mem_out,
  input logic [DATA_W-1:0] bus_out,
  input logic              bus_out_en,
  input logic              wr_pulse,
  input logic              prog_mode,
  input logic              mem_in,
  input logic              wr_en
);
  p_addr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |=> addr_q == $past(bus_in[ADDR_W-1:0]));

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_load |=> $stable(addr_q));

  p_test_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> eff_addr == sw_addr);

  p_reg_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> eff_addr == addr_q);

  p_bus_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_out |-> (bus_out == '0 && !bus_out_en));

  p_bus_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_out |-> bus_out_en);

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

  p_prog_blocks_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_mode && !wr_pulse) |-> !wr_en);

  p_btn_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_mode && !mem_in) |-> !wr_en);
endmodule

bind prog_mem_unit pmu_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_pmu_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_load (addr_load),
  .bus_in    (bus_in),
  .addr_q    (addr_q),
  .eff_addr  (eff_addr),
  .test_mode (test_mode),
  .sw_addr   (sw_addr),
  .mem_out   (mem_out),
  .bus_out   (bus_out),
  .bus_out_en(bus_out_en),
  .wr_pulse  (wr_pulse),
  .prog_mode (prog_mode),
  .mem_in    (mem_in),
  .wr_en     (wr_en)
);

// File: tb/test_prog_mem_unit.sv
`timescale 1ns/1ps
module test_prog_mem_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_in = '0;
  logic [7:0] bus_out;
  logic       bus_out_en;
  logic       addr_load = 1'b0, mem_in = 1'b0, mem_out = 1'b0;
  logic       test_mode = 1'b0, prog_mode = 1'b0;
  logic [3:0] sw_addr = '0;
  logic [7:0] sw_data = '0;
  logic       wr_btn = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  prog_mem_unit i_prog_mem_unit (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out),
    .bus_out_en(bus_out_en), .addr_load(addr_load), .mem_in(mem_in),
    .mem_out(mem_out), .test_mode(test_mode), .prog_mode(prog_mode),
    .sw_addr(sw_addr), .sw_data(sw_data), .wr_btn(wr_btn)
  );

  function automatic logic [7:0] bus_pat(input int a);
    return 8'((a * 29 + 7) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] sw_pat(input int a);
    return 8'((a * 53) ^ 8'hC3);
  endfunction

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Read location via switch address in test mode.
  task automatic read_sw(input int a, output logic [7:0] v);
    test_mode = 1'b1; sw_addr = 4'(a); mem_out = 1'b1;
    #1 v = bus_out;
    mem_out = 1'b0; test_mode = 1'b0;
  endtask

  task automatic load_addr(input logic [7:0] b);
    bus_in = b; addr_load = 1'b1;
    step();
    addr_load = 1'b0;
  endtask

  task automatic press();
    wr_btn = 1'b1; step(3);
    wr_btn = 1'b0; step(3);
  endtask

  initial begin
    logic [7:0] v;
    step(2);
    // R1 reset state
    check("R1 bus_out in reset", bus_out, 8'h00);
    check("R1 bus_out_en in reset", {7'd0, bus_out_en}, 8'h00);
    rst_n = 1'b1;
    step();
    mem_out = 1'b1; #1;
    check("R1 register 0 selects empty cell", bus_out, 8'h00);
    check("R6 bus_out_en when reading", {7'd0, bus_out_en}, 8'h01);
    mem_out = 1'b0;
    for (int a = 0; a < 16; a++) begin
      read_sw(a, v);
      check("R1 cell cleared", v, 8'h00);
    end

    // R4 bus writes via register addressing; R2 loads with noisy upper bits
    for (int a = 0; a < 16; a++) begin
      load_addr(8'((a ^ 5) << 4) | 8'(a));
      bus_in = bus_pat(a); mem_in = 1'b1;
      step();
      mem_in = 1'b0;
    end
    for (int a = 0; a < 16; a++) begin
      load_addr(8'hF0 | 8'(a));
      bus_in = 8'hFF; mem_out = 1'b1; #1;
      check("R4 R2 readback through register", bus_out, bus_pat(a));
      mem_out = 1'b0;
    end
    // R2 hold: register keeps address 9 with loads off
    load_addr(8'h09);
    bus_in = 8'h03; step(2);
    mem_out = 1'b1; #1;
    check("R2 register holds without load", bus_out, bus_pat(9));
    mem_out = 1'b0;
    // R6 idle output
    #1 check("R6 idle bus_out", bus_out, 8'h00);
    check("R6 idle bus_out_en", {7'd0, bus_out_en}, 8'h00);

    // R3 test-mode read and write override register (register = 9)
    for (int a = 0; a < 16; a++) begin
      read_sw(a, v);
      check("R3 test-mode read", v, bus_pat(a));
    end
    test_mode = 1'b1; sw_addr = 4'd2; bus_in = 8'hA5; mem_in = 1'b1;
    step();
    mem_in = 1'b0; test_mode = 1'b0;
    read_sw(2, v);  check("R3 test-mode write target", v, 8'hA5);
    read_sw(9, v);  check("R3 register cell untouched", v, bus_pat(9));

    // R8 button ignored outside programming mode
    test_mode = 1'b1; sw_addr = 4'd4; sw_data = 8'h11;
    press();
    test_mode = 1'b0;
    read_sw(4, v);  check("R8 button ignored", v, bus_pat(4));

    // R5 programming-mode sweep
    prog_mode = 1'b1; test_mode = 1'b1;
    for (int a = 0; a < 16; a++) begin
      sw_addr = 4'(a); sw_data = sw_pat(a);
      press();
    end
    for (int a = 0; a < 16; a++) begin
      read_sw(a, v);
      check("R5 programmed value", v, sw_pat(a));
    end
    // R5 timing: third edge after press
    test_mode = 1'b1; sw_addr = 4'd6; sw_data = 8'h3C; wr_btn = 1'b1;
    step(2);
    mem_out = 1'b1; #1;
    check("R5 not written after two edges", bus_out, sw_pat(6));
    step();
    #1 check("R5 written on third edge", bus_out, 8'h3C);
    mem_out = 1'b0;
    // R5 held button writes once
    sw_data = 8'h99; step(5);
    read_sw(6, v);  check("R5 single write per press", v, 8'h3C);
    wr_btn = 1'b0; step(3);

    // R7 bus write blocked in programming mode
    test_mode = 1'b1; sw_addr = 4'd7; bus_in = 8'hEE; mem_in = 1'b1;
    step(2);
    mem_in = 1'b0;
    read_sw(7, v);  check("R7 mem_in blocked", v, sw_pat(7));
    prog_mode = 1'b0;
    step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule